// File: doc/BRIEF.md
# Interrupt Dispatch Sequencer

This block carries out the hand-over of control to an interrupt handler once an interrupt has been granted upstream. A one-cycle start pulse captures the current program counter, the stack pointer and the handler vector byte. The block then runs a fixed sequence of machine cycles. Two idle cycles come first. The program counter is then pushed onto a descending stack, one byte per cycle, over a plain memory write port. Last, the program counter is loaded with the handler address. That address has a zero high byte, and its low byte is the vector.

The write port has no back-pressure. The strobe, address and data are valid together for one cycle, and the memory has to take the byte in that cycle. For this reason none of the pins uses a valid/ready handshake. The updated stack pointer and the new program counter stay on their outputs after the sequence ends, so the core can take them at the done pulse or at any later time. One cycle is one machine cycle. With the default parameters a dispatch takes exactly five of them.

Top module: `irq_dispatch_seq`

## Requirements
- R1: During and after reset, busy_o, done_o and mem_we_o are 0, and sp_o and pc_o read 0x0000.
- R2: A start pulse taken while idle makes busy_o high for exactly the five cycles that follow the sampling edge. In the first two of these cycles mem_we_o stays 0.
- R3: In the third cycle mem_we_o is 1, mem_addr_o equals the captured stack pointer minus 1 (modulo 2^16), and mem_wdata_o carries bits 15:8 of the captured program counter.
- R4: In the fourth cycle mem_we_o is 1, mem_addr_o equals the captured stack pointer minus 2 (modulo 2^16), and mem_wdata_o carries bits 7:0 of the captured program counter.
- R5: In the fifth cycle done_o is 1 for that single cycle and pc_o equals {8'h00, vector}. pc_o keeps this value until the next dispatch loads it again.
- R6: From the fifth cycle on, sp_o equals the captured stack pointer minus 2, with wrap-around below 0x0000. It keeps this value while the block is idle.
- R7: A start pulse that arrives while busy_o is 1 is ignored, and so is any change of pc_i, sp_i or vec_i after the start edge. The sequence in progress and its results do not change.
- R8: A start pulse in the first idle cycle after done_o begins a new dispatch at once.
- R9: The vector byte is one of 0x40, 0x48, 0x50, 0x58 or 0x60. The block passes it through unchanged into pc_o bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a dispatch |
| pc_i | input | 16 | Program counter to be saved |
| sp_i | input | 16 | Stack pointer before the push |
| vec_i | input | 8 | Handler vector low byte |
| mem_we_o | output | 1 | Stack byte write strobe |
| mem_addr_o | output | 16 | Stack byte write address |
| mem_wdata_o | output | 8 | Stack byte write data |
| sp_o | output | 16 | Updated stack pointer |
| pc_o | output | 16 | New program counter |
| done_o | output | 1 | Pulses in the cycle the new program counter becomes valid |
| busy_o | output | 1 | A dispatch is in progress |

## Verification
Some properties are checked by assertions on every cycle. These are: done_o is a single-cycle pulse and is always followed by an idle cycle, writes come in pairs of exactly two with the second address one below the first, the stack pointer at done is two below its value before the push, pc_o does not move while the block is idle, and every accepted vector is legal. Other behaviour can only be shown by the bench scenarios. This covers the exact cycle of each strobe and the byte values against the captured program counter, the stack wrap below address zero, and a stray start or input change in the middle of a sequence leaving the results unchanged. It also covers a new dispatch that starts right after done.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT    = 3'd1,
    ST_PUSH_HI = 3'd2,
    ST_PUSH_LO = 3'd3,
    ST_LOAD    = 3'd4
  } dsq_state_e;
endpackage

// File: rtl/dsq_ctrl.sv
module dsq_ctrl
  import dsq_pkg::*;
#(
  parameter int WAIT_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output dsq_state_e state_o,
  output logic       accept_o
);
  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

  dsq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_PUSH_HI;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PUSH_HI: state_d = ST_PUSH_LO;
      ST_PUSH_LO: state_d = ST_LOAD;
      ST_LOAD:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_LOAD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD) |=> (state_q == ST_IDLE)); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH_HI) |=> (state_q == ST_PUSH_LO)); // R7
endmodule

// File: rtl/dsq_stack.sv
module dsq_stack
  import dsq_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  dsq_state_e        state_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] sp_o
);
  localparam int PC_BYTES = ADDR_W / BYTE_W;

  logic [ADDR_W-1:0] pc_q, sp_q;
  logic [BYTE_W-1:0] pc_byte [PC_BYTES];

  for (genvar g = 0; g < PC_BYTES; g++) begin : g_split
    assign pc_byte[g] = pc_q[g*BYTE_W +: BYTE_W];
  end

  logic push_hi, push_lo;
  assign push_hi = (state_i == ST_PUSH_HI);
  assign push_lo = (state_i == ST_PUSH_LO);

  assign we_o    = push_hi || push_lo;
  assign addr_o  = sp_q - 1'b1;
  assign wdata_o = push_hi ? pc_byte[PC_BYTES-1] : pc_byte[0];
  assign sp_o    = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
    end else if (accept_i) begin
      pc_q <= pc_i;
      sp_q <= sp_i;
    end else if (we_o) begin
      sp_q <= sp_q - 1'b1;
    end
  end

  AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && $past(we_o)) |=> !we_o); // R3

  AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && $past(we_o)) |-> (addr_o == $past(addr_o) - 1'b1)); // R4
endmodule

// File: rtl/dsq_vector.sv
module dsq_vector
  import dsq_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  dsq_state_e        state_i,
  input  logic [BYTE_W-1:0] vec_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              done_o
);
  logic [BYTE_W-1:0] vec_q;
  logic [ADDR_W-1:0] pc_q, target;

  assign target = {{(ADDR_W-BYTE_W){1'b0}}, vec_q};
  assign done_o = (state_i == ST_LOAD);
  assign pc_o   = done_o ? target : pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q <= '0;
      pc_q  <= '0;
    end else begin
      if (accept_i) vec_q <= vec_i;
      if (done_o)   pc_q  <= target;
    end
  end

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |-> (vec_i inside {8'h40, 8'h48, 8'h50, 8'h58, 8'h60})); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5
endmodule

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq
  import dsq_pkg::*;
#(
  parameter int WAIT_CYC = 2,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [BYTE_W-1:0] vec_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              done_o,
  output logic              busy_o
);
  dsq_state_e state;
  logic       accept;

  dsq_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .state_o(state), .accept_o(accept)
  );

  dsq_stack #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .state_i(state),
    .pc_i(pc_i), .sp_i(sp_i), .we_o(mem_we_o), .addr_o(mem_addr_o),
    .wdata_o(mem_wdata_o), .sp_o(sp_o)
  );

  dsq_vector #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_vector (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .state_i(state),
    .vec_i(vec_i), .pc_o(pc_o), .done_o(done_o)
  );

  assign busy_o = (state != ST_IDLE);

  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R2

  AST_SP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sp_o == $past(sp_o, 2) - 2'd2)); // R6

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(pc_o)); // R5
endmodule

// File: tb/tb_irq_dispatch_seq.sv
module tb_irq_dispatch_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] pc_i = '0, sp_i = '0;
  logic [7:0]  vec_i = '0;
  logic        mem_we_o, done_o, busy_o;
  logic [15:0] mem_addr_o, sp_o, pc_o;
  logic [7:0]  mem_wdata_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_dispatch_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_i(pc_i), .sp_i(sp_i),
    .vec_i(vec_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .sp_o(sp_o), .pc_o(pc_o), .done_o(done_o),
    .busy_o(busy_o)
  );

  // {pc, sp, vec}
  localparam int NVEC = 6;
  localparam logic [39:0] VECS [NVEC] = '{
    {16'h1234, 16'hFFFE, 8'h40},
    {16'hABCD, 16'hC000, 8'h48},
    {16'h0000, 16'h8001, 8'h50},
    {16'hFFFF, 16'h0100, 8'h58},
    {16'h5A3C, 16'hDFF0, 8'h60},
    {16'h8000, 16'h0002, 8'h40}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one dispatch. glitch in 1..5 pulses start with junk inputs in that cycle (R7).
  task automatic dispatch(input logic [15:0] pc, input logic [15:0] sp,
                          input logic [7:0] vec, input int glitch);
    logic [15:0] pc_prev;
    pc_prev = pc_o;
    start_i = 1'b1; pc_i = pc; sp_i = sp; vec_i = vec;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      start_i = (n == glitch);
      pc_i = (n == glitch) ? ~pc : pc;
      sp_i = (n == glitch) ? ~sp : sp;
      vec_i = (n == glitch) ? 8'h48 : vec;
      if (n <= 5) check("R2 busy", {15'd0, busy_o}, 16'd1);
      else        check("R2 idle after five", {15'd0, busy_o}, 16'd0);
      case (n)
        1, 2: begin
          check("R2 no write in wait", {15'd0, mem_we_o}, 16'd0);
          check("R5 pc held before load", pc_o, pc_prev);
        end
        3: begin
          check("R3 we", {15'd0, mem_we_o}, 16'd1);
          check("R3 addr", mem_addr_o, sp - 16'd1);
          check("R3 data", {8'd0, mem_wdata_o}, {8'd0, pc[15:8]});
        end
        4: begin
          check("R4 we", {15'd0, mem_we_o}, 16'd1);
          check("R4 addr", mem_addr_o, sp - 16'd2);
          check("R4 data", {8'd0, mem_wdata_o}, {8'd0, pc[7:0]});
        end
        5: begin
          check("R5 done", {15'd0, done_o}, 16'd1);
          check("R5 R9 pc", pc_o, {8'h00, vec});
          check("R6 sp", sp_o, sp - 16'd2);
          check("R5 no write", {15'd0, mem_we_o}, 16'd0);
        end
        default: begin
          check("R5 done single", {15'd0, done_o}, 16'd0);
          check("R5 pc hold", pc_o, {8'h00, vec});
          check("R6 sp hold", sp_o, sp - 16'd2);
        end
      endcase
    end
    start_i = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 busy", {15'd0, busy_o}, 16'd0);
    check("R1 done", {15'd0, done_o}, 16'd0);
    check("R1 we", {15'd0, mem_we_o}, 16'd0);
    check("R1 sp", sp_o, 16'h0000);
    check("R1 pc", pc_o, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {15'd0, busy_o}, 16'd0);

    for (int i = 0; i < NVEC; i++) begin
      dispatch(VECS[i][39:24], VECS[i][23:8], VECS[i][7:0], 0);
      @(negedge clk);
    end

    // R7: stray start and junk inputs in each busy cycle
    for (int g = 1; g <= 5; g++) begin
      dispatch(16'h4321 + 16'(g), 16'hA000, 8'h58, g);
      @(negedge clk);
      check("R7 stray start ignored", {15'd0, busy_o}, 16'd0);
    end

    // R8: back-to-back dispatches, start in the first idle cycle after done
    dispatch(16'h1111, 16'h3000, 8'h50, 0);
    dispatch(16'h2222, 16'h2FFE, 8'h60, 0);

    // R6: stack wraps below zero, writes at 0x0000 then 0xFFFF
    @(negedge clk);
    dispatch(16'hBEEF, 16'h0001, 8'h48, 0);
    check("R6 wrap sp", sp_o, 16'hFFFF);

    // R1: reset in the middle of a dispatch
    start_i = 1'b1; pc_i = 16'h7777; sp_i = 16'h4000; vec_i = 8'h40;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset busy", {15'd0, busy_o}, 16'd0);
    check("R1 mid reset pc", pc_o, 16'h0000);
    check("R1 mid reset sp", sp_o, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule